// File: doc/BRIEF.md
# Banked address window translator

This block sits between a 16-bit CPU address bus and a 24-bit physical memory space. A contiguous slice of the CPU address map acts as a paged window: any address that falls inside it is rebased to the window start. The block then adds a page number, scaled by a configurable power of two, and a configurable physical base. Addresses outside the window pass straight through, widened with zeros. For the same CPU address, the block also decides which memory region answers: IO registers, EEPROM, non-volatile RAM or external RAM.

Each request is accepted in one cycle. Its response is presented, registered, on the following cycle. The IO block can be relocated in 4 KB steps by the low nibble of an 8-bit layout register, and the internal RAM by the high nibble of the same register. The EEPROM sits at a fixed, parameterized base. External RAM answers any address that no other region claims. Where regions overlap, the higher-priority one hides the lower one.

Software loads the layout register, the window bounds, the page shift and the physical base through a small write port. A write never alters a translation that is accepted in the same cycle.

Top module: `bank_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0 and the configuration holds layout 0x01, window start 0x8000, window end 0xC000, shift 14 and physical base 0x010000, so a request for 0x8000 on page 0 returns 0x010000.
- R2: `rsp_valid` is 1 in exactly the cycle after each cycle in which `req_valid` is 1, and 0 otherwise; back-to-back requests each get their own response.
- R3: An address equal to the window start is inside the window (`rsp_in_window` = 1).
- R4: The window end is exclusive: the address one below the end is translated, while the end address itself is passed through with `rsp_in_window` = 0.
- R5: Inside the window, `rsp_paddr` = (address − start) + (page << shift) + physical base, truncated to 24 bits.
- R6: Outside the window, `rsp_paddr` equals the CPU address zero-extended to 24 bits.
- R7: The IO region starts at layout[3:0] × 0x1000 and spans 64 bytes (1024 when `WIDE_IO` = 1); `rsp_region` bit 0 marks it.
- R8: The internal RAM region starts at layout[7:4] × 0x1000 and spans 256 bytes; `rsp_region` bit 2 marks it. The EEPROM spans 0xB000..0xB1FF and is marked by bit 1, and external RAM is marked by bit 3.
- R9: `rsp_region` is one-hot, with priority IO over EEPROM over internal RAM over external RAM, and external RAM is selected when no other region matches.
- R10: A configuration write that occurs in the same cycle as a request does not affect that request; it applies from the next request on.
- R11: Configuration writes use `cfg_sel` 0 = layout (wdata[7:0]), 1 = window start (wdata[15:0]), 2 = window end (wdata[15:0]), 3 = shift (wdata[4:0]), 4 = physical base (wdata[23:0]); writes with `cfg_sel` 5..7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 24 | Configuration write data |
| req_valid | input | 1 | Translation request |
| req_addr | input | 16 | CPU address |
| req_page | input | 8 | Current page number |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_paddr | output | 24 | Translated physical address |
| rsp_in_window | output | 1 | Address fell inside the paged window |
| rsp_region | output | 4 | One-hot region select: bit0 IO, bit1 EEPROM, bit2 internal RAM, bit3 external RAM |

## Verification
The bench tests both window bounds: the start address itself, the address just below the end, and the end address. A design with an inclusive end bound would translate the end address instead of passing it through. A design with an off-by-one start would pass the start address through. Large page numbers combined with a big shift check that the page term is neither truncated nor applied to the wrong bits. The layout register is moved so that IO, EEPROM and internal RAM overlap, which checks that the overlay order holds. A wrong order would flag the hidden region, or raise two select bits at once. Configuration writes are issued in the same cycle as a request, to catch a design that forwards fresh register values into a translation already accepted.

// File: rtl/bxl_pkg.sv
package bxl_pkg;

  localparam int ADDR_W  = 16;
  localparam int PAGE_W  = 8;
  localparam int PADDR_W = 24;
  localparam int SHIFT_W = 5;
  localparam int INIT_W  = 8;
  localparam int SEL_W   = 3;
  localparam int NUM_RGN = 4;
  localparam int NIB_POS = ADDR_W - 4;

  // Bit positions inside the one-hot region select, highest priority first.
  localparam int RGN_IO = 0;
  localparam int RGN_EE = 1;
  localparam int RGN_NV = 2;
  localparam int RGN_XR = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_LAYOUT = 3'd0,
    SEL_WSTART = 3'd1,
    SEL_WEND   = 3'd2,
    SEL_SHIFT  = 3'd3,
    SEL_PBASE  = 3'd4
  } cfg_sel_e;

  typedef struct packed {
    logic [INIT_W-1:0]  layout;
    logic [ADDR_W-1:0]  wstart;
    logic [ADDR_W-1:0]  wend;
    logic [SHIFT_W-1:0] shift;
    logic [PADDR_W-1:0] pbase;
  } xlate_cfg_t;

  localparam xlate_cfg_t CFG_RESET = '{
    layout: 8'h01,
    wstart: 16'h8000,
    wend:   16'hC000,
    shift:  5'd14,
    pbase:  24'h010000
  };

endpackage

// File: rtl/bxl_rst_sync.sv
module bxl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shreg_q;
  logic [STAGES-1:0] shreg_d;

  always_comb begin
    shreg_d = {shreg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
    end else begin
      shreg_q <= shreg_d;
    end
  end

  assign rst_sync_n = shreg_q[STAGES-1];

endmodule

// File: rtl/bxl_cfg_regs.sv
module bxl_cfg_regs
  import bxl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [PADDR_W-1:0] cfg_wdata,
  output xlate_cfg_t         cfg_q
);

  xlate_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    case (cfg_sel_e'(cfg_sel))
      SEL_LAYOUT: cfg_d.layout = cfg_wdata[INIT_W-1:0];
      SEL_WSTART: cfg_d.wstart = cfg_wdata[ADDR_W-1:0];
      SEL_WEND:   cfg_d.wend   = cfg_wdata[ADDR_W-1:0];
      SEL_SHIFT:  cfg_d.shift  = cfg_wdata[SHIFT_W-1:0];
      SEL_PBASE:  cfg_d.pbase  = cfg_wdata;
      default:    cfg_d        = cfg_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/bxl_window.sv
module bxl_window
  import bxl_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic [PAGE_W-1:0]  page,
  input  xlate_cfg_t         cfg,
  output logic               hit,
  output logic [PADDR_W-1:0] paddr
);

  localparam int EXT_W = PADDR_W - ADDR_W;
  localparam int PEXT  = PADDR_W - PAGE_W;

  logic [ADDR_W-1:0]  rel;
  logic [PADDR_W-1:0] rel_ext;
  logic [PADDR_W-1:0] page_term;
  logic [PADDR_W-1:0] addr_ext;

  always_comb begin
    // Lower bound is inclusive, upper bound is exclusive.
    hit       = (addr >= cfg.wstart) && (addr < cfg.wend);
    rel       = addr - cfg.wstart;
    rel_ext   = {{EXT_W{1'b0}}, rel};
    page_term = {{PEXT{1'b0}}, page} << cfg.shift;
    addr_ext  = {{EXT_W{1'b0}}, addr};
    paddr     = hit ? (rel_ext + page_term + cfg.pbase) : addr_ext;
  end

endmodule

// File: rtl/bxl_region_dec.sv
module bxl_region_dec
  import bxl_pkg::*;
#(
  parameter bit                WIDE_IO  = 1'b0,
  parameter logic [ADDR_W-1:0] EE_BASE  = 16'hB000,
  parameter int                EE_BYTES = 512,
  parameter int                NV_BYTES = 256
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [INIT_W-1:0]  layout,
  output logic [NUM_RGN-1:0] rgn
);

  localparam int IO_BYTES = WIDE_IO ? 1024 : 64;
  localparam int NRANGED  = NUM_RGN - 1;
  localparam int CW       = ADDR_W + 1;

  logic [CW-1:0]      rbase [NRANGED];
  logic [CW-1:0]      rlen  [NRANGED];
  logic [NRANGED-1:0] inr;
  logic [CW-1:0]      addr_w;

  assign addr_w    = {1'b0, addr};
  assign rbase[RGN_IO] = {1'b0, layout[3:0], {NIB_POS{1'b0}}};
  assign rbase[RGN_EE] = {1'b0, EE_BASE};
  assign rbase[RGN_NV] = {1'b0, layout[7:4], {NIB_POS{1'b0}}};
  assign rlen[RGN_IO]  = CW'(IO_BYTES);
  assign rlen[RGN_EE]  = CW'(EE_BYTES);
  assign rlen[RGN_NV]  = CW'(NV_BYTES);

  for (genvar g = 0; g < NRANGED; g++) begin : g_range
    assign inr[g] = (addr_w >= rbase[g]) && (addr_w < (rbase[g] + rlen[g]));
  end

  // Fixed overlay order: the lowest index wins.
  always_comb begin
    rgn = '0;
    if (inr[RGN_IO]) begin
      rgn[RGN_IO] = 1'b1;
    end else if (inr[RGN_EE]) begin
      rgn[RGN_EE] = 1'b1;
    end else if (inr[RGN_NV]) begin
      rgn[RGN_NV] = 1'b1;
    end else begin
      rgn[RGN_XR] = 1'b1;
    end
  end

endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bxl_pkg::*;
#(
  parameter bit                WIDE_IO  = 1'b0,
  parameter logic [ADDR_W-1:0] EE_BASE  = 16'hB000,
  parameter int                EE_BYTES = 512,
  parameter int                NV_BYTES = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [PADDR_W-1:0] cfg_wdata,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [PAGE_W-1:0]  req_page,
  output logic               rsp_valid,
  output logic [PADDR_W-1:0] rsp_paddr,
  output logic               rsp_in_window,
  output logic [NUM_RGN-1:0] rsp_region
);

  logic               rst_sync_n;
  xlate_cfg_t         cfg_q;
  logic               win_hit;
  logic [PADDR_W-1:0] win_paddr;
  logic [NUM_RGN-1:0] dec_rgn;
  logic [ADDR_W-1:0]  cur_wstart;
  logic [ADDR_W-1:0]  cur_wend;

  logic               vld_d;
  logic [PADDR_W-1:0] paddr_d;
  logic               inwin_d;
  logic [NUM_RGN-1:0] rgn_d;

  bxl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bxl_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q)
  );

  bxl_window u_win (
    .addr  (req_addr),
    .page  (req_page),
    .cfg   (cfg_q),
    .hit   (win_hit),
    .paddr (win_paddr)
  );

  bxl_region_dec #(
    .WIDE_IO  (WIDE_IO),
    .EE_BASE  (EE_BASE),
    .EE_BYTES (EE_BYTES),
    .NV_BYTES (NV_BYTES)
  ) u_dec (
    .addr   (req_addr),
    .layout (cfg_q.layout),
    .rgn    (dec_rgn)
  );

  assign cur_wstart = cfg_q.wstart;
  assign cur_wend   = cfg_q.wend;

  always_comb begin
    vld_d   = req_valid;
    paddr_d = win_paddr;
    inwin_d = win_hit;
    rgn_d   = dec_rgn;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_paddr     <= '0;
      rsp_in_window <= 1'b0;
      rsp_region    <= '0;
    end else if (req_valid) begin
      rsp_paddr     <= paddr_d;
      rsp_in_window <= inwin_d;
      rsp_region    <= rgn_d;
    end
  end

endmodule

// File: rtl/bxl_checker.sv
module bxl_checker
  import bxl_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               rsp_valid,
  input logic [PADDR_W-1:0] rsp_paddr,
  input logic               rsp_in_window,
  input logic [NUM_RGN-1:0] rsp_region,
  input logic [ADDR_W-1:0]  wstart,
  input logic [ADDR_W-1:0]  wend
);

  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r9_region_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_region) == 1));

  a_r6_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_in_window) |-> (rsp_paddr == {{(PADDR_W-ADDR_W){1'b0}}, $past(req_addr)}));

  a_r4_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr == wend)) |=> !rsp_in_window);

  a_r3_start_inclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr == wstart) && (wstart < wend)) |=> rsp_in_window);

endmodule

bind bank_xlate bxl_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .req_valid     (req_valid),
  .req_addr      (req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_paddr     (rsp_paddr),
  .rsp_in_window (rsp_in_window),
  .rsp_region    (rsp_region),
  .wstart        (cur_wstart),
  .wend          (cur_wend)
);

// File: tb/test_bank_xlate.sv
`timescale 1ns/1ps
module test_bank_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [23:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_page = '0;
  logic        rsp_valid;
  logic [23:0] rsp_paddr;
  logic        rsp_in_window;
  logic [3:0]  rsp_region;

  int n_checks = 0;
  int n_fail   = 0;
  bit mon_on   = 1'b0;

  typedef struct {
    logic [23:0] paddr;
    logic        inwin;
    logic [3:0]  rgn;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  // Bench-side copy of the configuration, per R11 encoding.
  logic [7:0]  m_layout = 8'h01;
  logic [15:0] m_ws = 16'h8000;
  logic [15:0] m_we = 16'hC000;
  logic [4:0]  m_sh = 5'd14;
  logic [23:0] m_pb = 24'h010000;

  always #2 clk = ~clk;

  bank_xlate i_bank_xlate (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_sel       (cfg_sel),
    .cfg_wdata     (cfg_wdata),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_page      (req_page),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_in_window (rsp_in_window),
    .rsp_region    (rsp_region)
  );

  function automatic exp_t model(input logic [15:0] a, input logic [7:0] pg, input string tag);
    exp_t e;
    int unsigned io_b, nv_b, ai;
    ai = a;
    e.tag = tag;
    e.inwin = (a >= m_ws) && (a < m_we);
    if (e.inwin) e.paddr = 24'((ai - m_ws) + (int'(pg) << m_sh) + m_pb);
    else         e.paddr = {8'h00, a};
    io_b = int'(m_layout[3:0]) * 4096;
    nv_b = int'(m_layout[7:4]) * 4096;
    if (ai >= io_b && ai < io_b + 64)            e.rgn = 4'b0001;
    else if (ai >= 32'hB000 && ai < 32'hB200)    e.rgn = 4'b0010;
    else if (ai >= nv_b && ai < nv_b + 256)      e.rgn = 4'b0100;
    else                                         e.rgn = 4'b1000;
    return e;
  endfunction

  task automatic fail(input string tag, input string what, input logic [23:0] act, input logic [23:0] exp);
    n_fail++;
    $display("FAIL %s %s: actual %06h expected %06h", tag, what, act, exp);
  endtask

  // One driven cycle: an optional request and an optional config write.
  task automatic step(input bit do_req, input logic [15:0] a, input logic [7:0] pg,
                      input bit do_cfg, input logic [2:0] sel, input logic [23:0] wd,
                      input string tag);
    @(posedge clk); #1;
    req_valid = do_req; req_addr = a; req_page = pg;
    cfg_we = do_cfg; cfg_sel = sel; cfg_wdata = wd;
    if (do_req) exp_q.push_back(model(a, pg, tag));
    if (do_cfg) begin
      case (sel)
        3'd0: m_layout = wd[7:0];
        3'd1: m_ws = wd[15:0];
        3'd2: m_we = wd[15:0];
        3'd3: m_sh = wd[4:0];
        3'd4: m_pb = wd;
        default: ;
      endcase
    end
  endtask

  task automatic req(input logic [15:0] a, input logic [7:0] pg, input string tag);
    step(1'b1, a, pg, 1'b0, 3'd0, 24'h0, tag);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [23:0] wd, input string tag);
    step(1'b0, 16'h0, 8'h0, 1'b1, sel, wd, tag);
  endtask

  task automatic idle();
    step(1'b0, 16'h0, 8'h0, 1'b0, 3'd0, 24'h0, "");
  endtask

  // Monitor: compares each response against the head of the queue.
  always @(negedge clk) begin
    if (mon_on && rsp_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        fail("R2", "response without request", 24'(rsp_valid), 24'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rsp_paddr !== e.paddr || rsp_in_window !== e.inwin || rsp_region !== e.rgn) begin
          fail(e.tag, "paddr", rsp_paddr, e.paddr);
          $display("FAIL %s window/region: actual %0b/%04b expected %0b/%04b",
                   e.tag, rsp_in_window, rsp_region, e.inwin, e.rgn);
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (rsp_valid !== 1'b0) fail("R1", "rsp_valid after reset", 24'(rsp_valid), 24'h0);
    mon_on = 1'b1;

    // Reset configuration and window bounds.
    req(16'h8000, 8'h00, "R1");
    req(16'h8000, 8'h00, "R3");
    req(16'hBFFF, 8'h00, "R4");
    req(16'hC000, 8'h00, "R4");
    req(16'h7FFF, 8'h00, "R6");
    idle();
    req(16'hFFFF, 8'h22, "R6");
    // Page arithmetic.
    req(16'h9234, 8'h03, "R5");
    req(16'hA000, 8'hFF, "R5");
    // Regions with layout 0x01.
    req(16'h1000, 8'h00, "R7");
    req(16'h103F, 8'h00, "R7");
    req(16'h1040, 8'h00, "R7");
    req(16'h0080, 8'h00, "R8");
    req(16'h0100, 8'h00, "R8");
    req(16'hB1FF, 8'h00, "R8");
    req(16'hB200, 8'h00, "R8");
    // Write in the same cycle as a request: request sees old layout.
    step(1'b1, 16'h1050, 8'h00, 1'b1, 3'd0, 24'h000011, "R10");
    req(16'h1050, 8'h00, "R10");
    req(16'h1010, 8'h00, "R9");
    wr(3'd0, 24'h0000BB, "R9");
    req(16'hB020, 8'h00, "R9");
    req(16'hB080, 8'h00, "R9");
    req(16'hB1F0, 8'h00, "R9");
    wr(3'd0, 24'h0000B0, "R9");
    req(16'hB080, 8'h00, "R9");
    req(16'hB300, 8'h00, "R9");
    // Unused selects change nothing.
    wr(3'd5, 24'hFFFFFF, "R11");
    wr(3'd6, 24'h123456, "R11");
    wr(3'd7, 24'h000000, "R11");
    req(16'h8000, 8'h01, "R11");
    req(16'hC000, 8'h00, "R11");
    req(16'h0000, 8'h00, "R11");
    // Narrow window, new shift and base.
    wr(3'd1, 24'h004000, "R11");
    wr(3'd2, 24'h004001, "R11");
    wr(3'd3, 24'h000000, "R11");
    wr(3'd4, 24'h800000, "R11");
    req(16'h4000, 8'h05, "R3");
    req(16'h4001, 8'h05, "R4");
    req(16'h3FFF, 8'h05, "R6");
    // Shift change concurrent with request.
    step(1'b1, 16'h4000, 8'h02, 1'b1, 3'd3, 24'h000010, "R10");
    req(16'h4000, 8'h02, "R5");
    idle();
    idle();
    @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) fail("R2", "unanswered requests", 24'(exp_q.size()), 24'h0);
    finish_run();
  end

endmodule